// File: doc/BRIEF.md
# Oscillator Sub-Band Search Controller

This controller picks the coarse sub-band of a PLL oscillator whose frequency is set in coarse steps by a switched-capacitor array. A start command makes it hold the analogue loop open and pin the oscillator tuning voltage to its fixed reference level. It then searches the capacitor word one bit at a time. For each trial word it waits a programmable settling time. It then counts the rising edges of the divided feedback signal over a programmable number of reference-clock cycles and compares that count with a programmed target.

The search is a binary search that starts at the most significant bit. A larger word value means more capacitance, and so a lower feedback frequency. When the search is finished, the controller releases both analogue-control outputs so that the analogue loop can fine-lock. It raises a one-cycle completion pulse, and it keeps the chosen word on its output until the next start. All logic runs on the reference clock. The feedback signal is treated as asynchronous and passes through a synchronizer before its edges are counted.

Top module: `vco_band_cal`

## Requirements
- R1: During and after a synchronous reset, loop_open, vtune_force and done are 0, and cap_word is 0.
- R2: A start seen while idle makes loop_open and vtune_force go to 1 in the next cycle. The two outputs stay equal to each other in every cycle, and both stay high until the search ends.
- R3: Each trial sets the bit under test to 1, with every lower bit at 0. The first trial word is 6'b100000. The bit under test moves from bit 5 down to bit 0. A larger cap_word means more capacitance and a lower feedback frequency.
- R4: When the edge count is below target, the bit under test is cleared. When the count is above target, the bit is kept.
- R5: When the edge count equals target, the bit under test is kept and the search ends after that trial.
- R6: Each trial first waits settle_len cycles. It then counts the synchronized rising edges of fb_in over exactly win_len reference cycles. Both values are at least 1.
- R7: loop_open stays high for exactly 1 + k*(settle_len + win_len + 2) cycles, where k is the number of trials performed.
- R8: done is 1 for exactly one cycle. That cycle is the first cycle in which loop_open and vtune_force are low again.
- R9: After done, cap_word holds the chosen word until the next start. A start that arrives while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (acted on only when idle) |
| win_len | input | 16 | Measurement window length in reference cycles |
| settle_len | input | 16 | Wait after each word change in reference cycles |
| target | input | 16 | Expected feedback edge count per window |
| fb_in | input | 1 | Divided feedback signal, asynchronous |
| loop_open | output | 1 | Holds the analogue loop disconnected |
| vtune_force | output | 1 | Pins the tuning voltage to its reference level |
| cap_word | output | 6 | Capacitor-array control word |
| done | output | 1 | One-cycle search-complete pulse |

## Verification
The assertions assume the following about the inputs. settle_len and win_len are nonzero, and the programmed values stay constant during a search. fb_in holds each level for at least one full reference cycle. Each settle period is longer than the synchronizer latency, so a window never contains edges left over from the previous word. The stimulus keeps to these limits: the feedback model is driven once per reference cycle, each feedback period is a whole number of cycles, and every period restarts in phase when cap_word changes. Settle times are at least five cycles, and every window length is a multiple of every model period, so each expected count is exact.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN_LOOP,
        ST_SETTLE,
        ST_MEASURE,
        ST_COMPARE,
        ST_NEXT_BIT,
        ST_DONE
    } cal_state_e;

    typedef enum logic [1:0] {
        CMP_SLOW,
        CMP_MATCH,
        CMP_FAST
    } cmp_e;

    // Frequency verdict: a count below target means the oscillator runs slow.
    function automatic cmp_e classify(input logic [31:0] cnt, input logic [31:0] tgt);
        if (cnt < tgt)       return CMP_SLOW;
        else if (cnt == tgt) return CMP_MATCH;
        else                 return CMP_FAST;
    endfunction

    // Ones in every bit position strictly below idx.
    function automatic logic [31:0] below_mask(input int unsigned idx);
        return (32'd1 << idx) - 32'd1;
    endfunction

endpackage

// File: rtl/fb_edge_sync.sv
module fb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_async,
    output logic fb_rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], fb_async};
    end

    assign fb_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/cal_counter.sv
module cal_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (inc)   q <= q + 1'b1;
    end
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
    parameter int WORD_W      = 6,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  win_len,
    input  logic [CNT_W-1:0]  settle_len,
    input  logic [CNT_W-1:0]  target,
    input  logic              fb_in,
    output logic              loop_open,
    output logic              vtune_force,
    output logic [WORD_W-1:0] cap_word,
    output logic              done
);
    import cal_pkg::*;

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic              matched;
    } search_t;

    cal_state_e        st;
    search_t           srch;
    logic              fb_rise;
    logic [CNT_W-1:0]  tmr;
    logic [CNT_W-1:0]  edge_cnt;
    logic [CNT_W:0]    tmr_next;
    logic              settle_end, meas_end, tmr_clr, tmr_inc, cnt_inc;
    logic              hold_analog;

    fb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .fb_async(fb_in), .fb_rise(fb_rise)
    );

    assign tmr_next   = {1'b0, tmr} + 1'b1;
    assign settle_end = (st == ST_SETTLE)  && (tmr_next >= {1'b0, settle_len});
    assign meas_end   = (st == ST_MEASURE) && (tmr_next >= {1'b0, win_len});
    assign tmr_clr    = (st == ST_OPEN_LOOP) || (st == ST_NEXT_BIT) || settle_end;
    assign tmr_inc    = (st == ST_SETTLE) || (st == ST_MEASURE);
    assign cnt_inc    = (st == ST_MEASURE) && fb_rise;

    cal_counter #(.W(CNT_W)) u_window (
        .clk(clk), .rst(rst), .clr(tmr_clr), .inc(tmr_inc), .q(tmr)
    );

    cal_counter #(.W(CNT_W)) u_edges (
        .clk(clk), .rst(rst), .clr(settle_end), .inc(cnt_inc), .q(edge_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            srch <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    srch.word    <= '0;
                    srch.idx     <= TOP_IDX;
                    srch.matched <= 1'b0;
                    st           <= ST_OPEN_LOOP;
                end
                ST_OPEN_LOOP: begin
                    srch.word <= WORD_W'(1) << TOP_IDX;
                    st        <= ST_SETTLE;
                end
                ST_SETTLE:  if (settle_end) st <= ST_MEASURE;
                ST_MEASURE: if (meas_end)   st <= ST_COMPARE;
                ST_COMPARE: begin
                    unique case (classify(32'(edge_cnt), 32'(target)))
                        CMP_SLOW:  srch.word[srch.idx] <= 1'b0;
                        CMP_MATCH: srch.matched        <= 1'b1;
                        default:   ;
                    endcase
                    st <= ST_NEXT_BIT;
                end
                ST_NEXT_BIT: begin
                    if (srch.matched || srch.idx == '0) begin
                        st <= ST_DONE;
                    end else begin
                        srch.idx  <= srch.idx - 1'b1;
                        srch.word <= srch.word | (WORD_W'(1) << (srch.idx - 1'b1));
                        st        <= ST_SETTLE;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign hold_analog = (st != ST_IDLE) && (st != ST_DONE);
    assign loop_open   = hold_analog;
    assign vtune_force = hold_analog;
    assign cap_word    = srch.word;
    assign done        = (st == ST_DONE);

    // R2: analogue hold only begins in response to a start command
    assert_open_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(loop_open) |-> $past(start));

    // R3: while settling, the trial bit is set and every lower bit is clear
    assert_trial_shape_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE) |-> (srch.word[srch.idx] &&
            ((srch.word & WORD_W'(below_mask(32'(srch.idx)))) == '0)));

    // R6: a window cannot collect more edges than cycles elapsed
    assert_edge_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MEASURE) |-> (edge_cnt <= tmr));

    // R8: release of the loop coincides with the completion pulse
    assert_release_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(loop_open) |-> done);

    // R8: completion pulse lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the chosen word holds while idle without a start
    assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> $stable(cap_word));

    // R9: start during a search does not restart it
    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && start) |=> (st != ST_OPEN_LOOP));
endmodule

// File: tb/vco_band_cal_test.sv
module vco_band_cal_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] win_len = 16'd60;
    logic [15:0] settle_len = 16'd8;
    logic [15:0] target = 16'd0;
    logic        fb_in = 1'b0;
    logic        loop_open, vtune_force, done;
    logic [5:0]  cap_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    vco_band_cal uut (
        .clk(clk), .rst(rst), .start(start), .win_len(win_len),
        .settle_len(settle_len), .target(target), .fb_in(fb_in),
        .loop_open(loop_open), .vtune_force(vtune_force),
        .cap_word(cap_word), .done(done)
    );

    always #10 clk = ~clk;  // 50 MHz

    // Oscillator model: more capacitance (larger word) gives a longer feedback period.
    function automatic int period_of(input logic [5:0] w);
        case ((int'(w) * 11) >> 6)
            0: return 2;   1: return 3;   2: return 4;   3: return 5;
            4: return 6;   5: return 10;  6: return 12;  7: return 15;
            8: return 20;  9: return 30;  default: return 60;
        endcase
    endfunction

    logic [5:0] last_w = 6'd0;
    int phase = 0;
    always @(negedge clk) begin
        if (cap_word !== last_w) begin
            last_w = cap_word;
            phase  = 0;
        end
        fb_in = (phase == 0);
        phase = (phase + 1) % period_of(cap_word);
    end

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles > 200000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles, expected under 200000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input int tgt, input int w, input int s, input bit poke);
        int exp_word = 0;
        int trials = 0;
        bit early = 0;
        int open_cyc = 0;
        int pair_bad = 0;
        // reference search from R3, R4, R5
        for (int b = 5; b >= 0; b--) begin
            int c;
            exp_word = exp_word | (1 << b);
            trials++;
            c = w / period_of(6'(exp_word));
            if (c < tgt) exp_word = exp_word & ~(1 << b);
            else if (c == tgt) begin early = 1; break; end
        end
        @(negedge clk);
        target = 16'(tgt); win_len = 16'(w); settle_len = 16'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(loop_open === 1'b1 && vtune_force === 1'b1, "R2 hold after start", int'(loop_open), 1);
        while (loop_open === 1'b1) begin
            open_cyc++;
            if (vtune_force !== loop_open) pair_bad++;
            if (open_cyc == 2)
                check(cap_word === 6'd32, "R3 first trial word", int'(cap_word), 32);
            start = (poke && open_cyc == 50);
            @(negedge clk);
        end
        start = 1'b0;
        check(pair_bad == 0, "R2 force tracks open", pair_bad, 0);
        check(done === 1'b1, "R8 done at release", int'(done), 1);
        check(open_cyc == 1 + trials * (s + w + 2), "R7 open duration (R6 window)",
              open_cyc, 1 + trials * (s + w + 2));
        if (early)
            check(cap_word === 6'(exp_word), "R5 match word", int'(cap_word), exp_word);
        else
            check(cap_word === 6'(exp_word), "R4 final word", int'(cap_word), exp_word);
        @(negedge clk);
        check(done === 1'b0, "R8 done one cycle", int'(done), 0);
        repeat (10) @(negedge clk);
        check(cap_word === 6'(exp_word) && loop_open === 1'b0, "R9 word held",
              int'(cap_word), exp_word);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(loop_open === 1'b0 && vtune_force === 1'b0 && done === 1'b0 &&
              cap_word === 6'd0, "R1 reset state", int'(cap_word), 0);
        rst = 1'b0;
        @(negedge clk);
        check(loop_open === 1'b0 && done === 1'b0, "R1 idle after reset", int'(loop_open), 0);
        for (int t = 0; t < 32; t++) run(t, 60, 8, 1'b0);
        for (int t = 0; t < 62; t += 3) run(t, 120, 5, 1'b0);
        run(10, 60, 8, 1'b1);  // R9 start during search ignored
        run(7, 60, 6, 1'b1);   // R9 start during search ignored
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule